// File: doc/BRIEF.md
# Output Compare Pin Action Unit

This unit watches a shared free-running count value that it receives from outside and compares it in parallel against five 16-bit compare values. Each compare channel raises a status flag when the count reaches its value, and it can drive a dedicated output pin. Channel 0 is the master channel. Its mask and data registers let it load any subset of all five pins in a single cycle. Channels 1 to 4 are slave channels. Channel k drives pin k with a 2-bit action code. When the master channel and a slave channel both act on the same pin, the master's action wins.

Software programs the unit through a single-cycle write port (`wrEn`, `wrSel`, `wrData`). The write port sets the compare values, the action codes, the master mask and data, the interrupt enables, the flag clears, and a force strobe. The force strobe applies a channel's pin action at once without waiting for a match. A match is an event, not a level. A channel fires only on the cycle in which the incoming count has just changed to equal its compare value. A count that holds at that value therefore fires once.

Top module: `compare_pin_unit`

## Requirements
- R1: Writing `wrSel` code i (0..4) loads compare register i from `wrData`. When `count` differs from its value in the previous cycle and equals compare register i, flag bit i is set at the next clock edge. A count that stays at the matching value does not fire again.
- R2: Slave channel k (1..4) drives `pinOut[k]`, and its action code sits in bits [2k-1:2k-2] of the mode register (`wrSel` code 5). When the channel fires, code 00 leaves the pin as it is, 01 inverts it, 10 drives it to 0 and 11 drives it to 1.
- R3: When master channel 0 fires, every pin p whose bit p is set in the mask register (`wrSel` code 6) takes bit p of the data register (`wrSel` code 7). All of these pins change on the same edge.
- R4: When the master channel and slave channel k fire in the same cycle and mask bit k is set, `pinOut[k]` takes the master data bit and ignores the slave's action.
- R5: `irq` is high exactly when some flag bit is set and the matching bit of the enable register (`wrSel` code 8) is also set.
- R6: A write with `wrSel` code 10 fires the pin action of every channel whose bit is 1 in `wrData`, at that clock edge. Bits that are 0 have no effect.
- R7: A forced action does not set any flag and therefore cannot raise `irq`.
- R8: A write with `wrSel` code 9 clears each flag whose `wrData` bit is 1 and leaves flags with a 0 bit unchanged. If a clear and a match hit the same flag in the same cycle, the flag stays set.
- R9: After reset, the pins, flags, enables, mode, mask and data registers are all 0, and every compare register holds all ones. Codes 11 to 15 on `wrSel` write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| count | input | 16 | Shared free-running count value |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 4 | Register select code |
| wrData | input | 16 | Write data |
| pinOut | output | 5 | Output pins; pin k belongs to slave channel k |
| flags | output | 5 | Channel status flags |
| irq | output | 1 | Interrupt request |

## Verification
Every result of this unit appears one clock edge after the stimulus that causes it. This holds for a match on the count, a forced action, a write and a flag clear. `irq` follows the registered flags without adding a further cycle. The bench applies each stimulus on a falling edge and updates its own model for the rising edge that follows. It then compares pins, flags and `irq` on the next falling edge, so each check lands exactly one edge after its stimulus. Directed steps cover held counts, master priority, forcing and clear-versus-set collisions. These are followed by seeded random traffic over a small count range, which makes matches frequent.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  localparam int CH_COUNT = 5;

  typedef enum logic [3:0] {
    SEL_CMP0  = 4'd0,
    SEL_MODE  = 4'd5,
    SEL_MASK  = 4'd6,
    SEL_DATA  = 4'd7,
    SEL_IEN   = 4'd8,
    SEL_CLR   = 4'd9,
    SEL_FORCE = 4'd10
  } selCode_t;

  typedef struct packed {
    logic [CH_COUNT-1:0] hit;
    logic [CH_COUNT-1:0] frc;
  } ocStrobe_t;
endpackage

// File: rtl/ocu_ctrl.sv
module ocu_ctrl
  import ocu_pkg::*;
#(
  parameter int NUM_CH = CH_COUNT,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] count,
  input  logic             wrEn,
  input  logic [3:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  output ocStrobe_t        strobes,
  output logic [NUM_CH-1:0] flags,
  output logic             irq
);
  logic [CNT_W-1:0]  cmpReg [NUM_CH];
  logic [CNT_W-1:0]  cntPrev;
  logic [NUM_CH-1:0] flagReg;
  logic [NUM_CH-1:0] ienReg;
  logic [NUM_CH-1:0] hitVec;
  logic [NUM_CH-1:0] frcVec;
  logic [NUM_CH-1:0] clrVec;
  logic              countMoved;

  assign countMoved = (count != cntPrev);
  assign frcVec = (wrEn && wrSel == SEL_FORCE) ? wrData[NUM_CH-1:0] : '0;
  assign clrVec = (wrEn && wrSel == SEL_CLR) ? wrData[NUM_CH-1:0] : '0;

  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : g_chan
      assign hitVec[i] = countMoved && (count == cmpReg[i]);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          cmpReg[i] <= '1;
        end else if (wrEn && wrSel == 4'(i)) begin
          cmpReg[i] <= wrData;
        end
      end

      assert_flag_from_match_R1: assert property (@(posedge clk) disable iff (!rstN)
        $rose(flagReg[i]) |-> ($past(count) == $past(cmpReg[i])));

      assert_force_no_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
        (!flagReg[i] && frcVec[i] && !hitVec[i]) |=> !flagReg[i]);

      assert_clear_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
        (flagReg[i] && clrVec[i] && !hitVec[i]) |=> !flagReg[i]);

      assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
        hitVec[i] |=> flagReg[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntPrev <= '0;
      flagReg <= '0;
      ienReg  <= '0;
    end else begin
      cntPrev <= count;
      flagReg <= (flagReg & ~clrVec) | hitVec;
      if (wrEn && wrSel == SEL_IEN) ienReg <= wrData[NUM_CH-1:0];
    end
  end

  assign strobes.hit = hitVec;
  assign strobes.frc = frcVec;
  assign flags = flagReg;
  assign irq = |(flagReg & ienReg);

  assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ienReg == '0) |-> !irq);
endmodule

// File: rtl/ocu_datapath.sv
module ocu_datapath
  import ocu_pkg::*;
#(
  parameter int NUM_CH = CH_COUNT,
  localparam int MODE_W = 2 * (NUM_CH - 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrSel,
  input  logic [MODE_W-1:0] wrData,
  input  ocStrobe_t         strobes,
  output logic [NUM_CH-1:0] pinOut
);
  logic [MODE_W-1:0] modeReg;
  logic [NUM_CH-1:0] maskReg;
  logic [NUM_CH-1:0] dataReg;
  logic [NUM_CH-1:0] pinReg;
  logic [NUM_CH-1:0] pinNext;
  logic [NUM_CH-1:0] fire;

  assign fire = strobes.hit | strobes.frc;

  genvar p;
  generate
    for (p = 0; p < NUM_CH; p++) begin : g_pin
      logic slaveLevel;
      if (p == 0) begin : g_master_only
        assign slaveLevel = pinReg[p];
      end else begin : g_slave
        logic [1:0] act;
        assign act = modeReg[2*(p-1) +: 2];
        always_comb begin
          slaveLevel = pinReg[p];
          if (fire[p]) begin
            case (act)
              2'b01:   slaveLevel = ~pinReg[p];
              2'b10:   slaveLevel = 1'b0;
              2'b11:   slaveLevel = 1'b1;
              default: slaveLevel = pinReg[p];
            endcase
          end
        end

        assert_toggle_R2: assert property (@(posedge clk) disable iff (!rstN)
          (fire[p] && !(fire[0] && maskReg[p]) && act == 2'b01)
          |=> (pinReg[p] != $past(pinReg[p])));
      end

      assign pinNext[p] = (fire[0] && maskReg[p]) ? dataReg[p] : slaveLevel;

      assert_master_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
        (fire[0] && maskReg[p]) |=> (pinReg[p] == $past(dataReg[p])));

      assert_pin_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
        (!(fire[0] && maskReg[p]) && !(p > 0 && fire[p])) |=> $stable(pinReg[p]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      maskReg <= '0;
      dataReg <= '0;
      pinReg  <= '0;
    end else begin
      if (wrEn && wrSel == SEL_MODE) modeReg <= wrData;
      if (wrEn && wrSel == SEL_MASK) maskReg <= wrData[NUM_CH-1:0];
      if (wrEn && wrSel == SEL_DATA) dataReg <= wrData[NUM_CH-1:0];
      pinReg <= pinNext;
    end
  end

  assign pinOut = pinReg;
endmodule

// File: rtl/compare_pin_unit.sv
module compare_pin_unit
  import ocu_pkg::*;
#(
  parameter int NUM_CH = CH_COUNT,
  parameter int CNT_W  = 16,
  localparam int MODE_W = 2 * (NUM_CH - 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  count,
  input  logic              wrEn,
  input  logic [3:0]        wrSel,
  input  logic [CNT_W-1:0]  wrData,
  output logic [NUM_CH-1:0] pinOut,
  output logic [NUM_CH-1:0] flags,
  output logic              irq
);
  ocStrobe_t strobes;

  ocu_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .count(count), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .strobes(strobes), .flags(flags), .irq(irq)
  );

  ocu_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData[MODE_W-1:0]), .strobes(strobes), .pinOut(pinOut)
  );
endmodule

// File: tb/tb_compare_pin_unit.sv
`timescale 1ns/1ps
module tb_compare_pin_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] count = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrSel = '0;
  logic [15:0] wrData = '0;
  logic [4:0]  pinOut, flags;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;

  logic [15:0] eCmp [5];
  logic [7:0]  eMode;
  logic [4:0]  eMask, eData, eIen, eFlag, ePin;
  logic [15:0] ePrev;

  always #10 clk = ~clk;

  compare_pin_unit dut (
    .clk(clk), .rstN(rstN), .count(count), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .pinOut(pinOut), .flags(flags), .irq(irq)
  );

  function automatic logic slaveAct(input logic [1:0] code, input logic cur);
    case (code)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  task automatic check(input string tag);
    logic eIrq;
    eIrq = |(eFlag & eIen);
    vectors++;
    if (pinOut !== ePin || flags !== eFlag || irq !== eIrq) begin
      miscompares++;
      $display("FAIL %s pins=%b exp %b flags=%b exp %b irq=%b exp %b",
               tag, pinOut, ePin, flags, eFlag, irq, eIrq);
    end
  endtask

  task automatic cycle(input logic [15:0] c, input logic we, input logic [3:0] sel,
                       input logic [15:0] d, input string tag);
    logic [4:0] hit, frc, clr, fire, nPin;
    count = c; wrEn = we; wrSel = sel; wrData = d;
    for (int i = 0; i < 5; i++) hit[i] = (c != ePrev) && (c == eCmp[i]);
    frc = (we && sel == 4'd10) ? d[4:0] : 5'd0;
    clr = (we && sel == 4'd9) ? d[4:0] : 5'd0;
    fire = hit | frc;
    nPin = ePin;
    for (int p = 1; p < 5; p++)
      if (fire[p]) nPin[p] = slaveAct(eMode[2*p-1 -: 2], ePin[p]);
    for (int p = 0; p < 5; p++)
      if (fire[0] && eMask[p]) nPin[p] = eData[p];
    ePin = nPin;
    eFlag = (eFlag & ~clr) | hit;
    ePrev = c;
    if (we) begin
      if (sel <= 4'd4) eCmp[sel] = d;
      else if (sel == 4'd5) eMode = d[7:0];
      else if (sel == 4'd6) eMask = d[4:0];
      else if (sel == 4'd7) eData = d[4:0];
      else if (sel == 4'd8) eIen = d[4:0];
    end
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    check(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] c;
    void'($urandom(32'd2718));
    for (int i = 0; i < 5; i++) eCmp[i] = 16'hFFFF;
    eMode = '0; eMask = '0; eData = '0; eIen = '0; eFlag = '0; ePin = '0; ePrev = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R9 reset state");
    for (int k = 0; k < 4; k++) cycle(16'(k), 1'b0, 4'd0, 16'd0, "R9 no match at reset values");
    cycle(16'd3, 1'b1, 4'd12, 16'h0003, "R9 unused select code");
    cycle(16'd3, 1'b0, 4'd0, 16'd0, "R9 unused select code writes nothing");
    cycle(16'd3, 1'b1, 4'd1, 16'd5, "R1 load compare 1");
    cycle(16'd3, 1'b1, 4'd5, 16'h0039, "R2 modes toggle/low/high/none");
    cycle(16'd4, 1'b0, 4'd0, 16'd0, "R1 before match");
    cycle(16'd5, 1'b0, 4'd0, 16'd0, "R1 R2 match toggles pin 1");
    for (int k = 0; k < 3; k++) cycle(16'd5, 1'b0, 4'd0, 16'd0, "R1 held count fires once");
    cycle(16'd5, 1'b1, 4'd8, 16'h0002, "R5 enable raises irq");
    cycle(16'd5, 1'b1, 4'd9, 16'h0000, "R8 zero clear keeps flag");
    cycle(16'd5, 1'b1, 4'd9, 16'h0002, "R8 clear flag drops irq R5");
    cycle(16'd6, 1'b1, 4'd2, 16'd9, "R1 load compare 2");
    cycle(16'd6, 1'b1, 4'd3, 16'd9, "R1 load compare 3");
    cycle(16'd7, 1'b1, 4'd4, 16'd9, "R1 load compare 4");
    cycle(16'd8, 1'b0, 4'd0, 16'd0, "R2 before shared match");
    cycle(16'd9, 1'b0, 4'd0, 16'd0, "R2 low high none actions");
    cycle(16'd9, 1'b1, 4'd6, 16'h001A, "R3 master mask");
    cycle(16'd9, 1'b1, 4'd7, 16'h0002, "R3 master data");
    cycle(16'd9, 1'b1, 4'd0, 16'd12, "R3 master compare");
    cycle(16'd10, 1'b1, 4'd3, 16'd12, "R4 slave compare on same value");
    cycle(16'd12, 1'b0, 4'd0, 16'd0, "R3 R4 master loads masked pins and wins");
    cycle(16'd12, 1'b1, 4'd10, 16'h0008, "R6 R7 force slave 3 high without flag");
    cycle(16'd12, 1'b1, 4'd10, 16'h0000, "R6 force zero no effect");
    cycle(16'd12, 1'b1, 4'd10, 16'h0001, "R6 R7 force master");
    cycle(16'd12, 1'b1, 4'd4, 16'd20, "R1 reload compare 4");
    cycle(16'd20, 1'b1, 4'd9, 16'h0010, "R8 set wins over clear");
    cycle(16'd20, 1'b1, 4'd8, 16'h001F, "R5 all enables");
    c = 16'd20;
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] sel;
      logic [15:0] d;
      if ($urandom_range(0, 3) != 0) c = (c + 16'd1) & 16'h001F;
      sel = 4'($urandom_range(0, 12));
      d = 16'($urandom);
      if (sel <= 4'd4) d = d & 16'h001F;
      cycle(c, ($urandom_range(0, 2) == 0), sel, d, "random mix R1 R2 R3 R4 R6 R8");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule